// File: doc/BRIEF.md
# Binary-Code Spread Spectrum Matched Filter

This block is a tapped-delay-line correlator. It looks for a known binary spreading sequence in a stream of quantised baseband samples. Each accepted sample moves into a 64-slot delay line. Each slot is weighted by +1 or -1, chosen by one bit of a reference code. Because the weights are bipolar, no multiplier is needed: a weight of -1 just negates the sample. All weighted slots are summed for every accepted sample, and a detector raises a pulse when the size of the sum reaches a programmed threshold. The cycle of that pulse marks the code timing used for acquisition.

The block has three sample interpretations, selected by a mode input. In the first, the 4-bit sample is a signed real value. In the second, only bit 0 is used as a one-bit hard decision. In the third, the sample is split into a 2-bit in-phase part and a 2-bit quadrature part, and a separate sum is formed for each. The reference code is shifted in one bit per cycle, and correlation is suspended while it loads. The sample leaving the oldest slot is presented on a cascade output, so a second block fed from it with the same valid strobe extends the delay line. The two blocks' sums are then added outside.

Top module: `spread_code_matcher`

## Requirements
- R1: While reset is held, and until the first accepted sample has produced a result, `out_valid` and `peak` are 0 and `corr_i`, `corr_q` and `casc_sample` are 0. Reset fills the delay line and the code register with zeros.
- R2: With `mode` = 0, each slot holds a 4-bit two's complement value s_j. `corr_i` = sum over j of w_j·s_j, where slot 0 is the newest accepted sample and w_j = +1 if code bit j is 0 and -1 if it is 1. `corr_q` = 0.
- R3: With `mode` = 1, only bit 0 of each slot is used: 0 means +1 and 1 means -1. `corr_i` therefore equals 64 minus twice the number of slots whose bit differs from the code bit, and `corr_q` = 0.
- R4: With `mode` = 2, bits [3:2] of a slot are a signed 2-bit in-phase value and bits [1:0] are a signed 2-bit quadrature value. `corr_i` and `corr_q` are the separately weighted sums of these values.
- R5: When `load_en` is 1, the code register shifts left by one and takes `load_bit` into bit 0. After 64 loads, the first bit loaded weights the oldest slot (slot 63). A stream that carries the code in loading order therefore gives a full-scale sum once its last chip is accepted.
- R6: While `load_en` is 1, `in_valid` is ignored. No sample enters the delay line, `casc_sample` does not change, and no result is produced from that cycle.
- R7: A sample accepted at a clock edge (`in_valid` = 1, `load_en` = 0) produces a result at the next edge. `out_valid` is 1 for exactly that one cycle per accepted sample.
- R8: `peak` is 1 only together with `out_valid`. In modes 0, 1 and 3 it is set when |`corr_i`| ≥ `threshold`; in mode 2 it is set when `corr_i`² + `corr_q`² ≥ `threshold`.
- R9: `casc_sample` equals the contents of slot 63, which is the sample accepted 64 accepted-samples earlier.
- R10: `corr_i` and `corr_q` keep their last result in cycles where `out_valid` is 0.
- R11: `mode` = 3 gives the same behaviour as `mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0/3 real 4-bit, 1 one-bit, 2 complex 2+2 bit |
| load_en | input | 1 | Shift one reference code bit this cycle |
| load_bit | input | 1 | Code bit being loaded (1 means weight -1) |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 4 | Received sample |
| threshold | input | 22 | Peak threshold (magnitude or power) |
| out_valid | output | 1 | New correlation result |
| corr_i | output | 11 | Signed in-phase (or real) correlation |
| corr_q | output | 11 | Signed quadrature correlation |
| peak | output | 1 | Detection pulse |
| casc_sample | output | 4 | Oldest slot, drives a following block |

## Verification
The hardest condition to reach is a full-scale correlation. It needs all 64 delay-line slots aligned chip for chip with a code that was loaded serially beforehand, and random samples almost never produce it. The bench keeps the code bits it loaded and then transmits them in loading order, in each mode. It also sends the inverted code in one-bit mode to reach the negative extreme. It checks the exact sum and the peak pulse in the cycle after the last chip is accepted. It also asserts the sample strobe during code loading, to show that loading freezes the delay line.

// File: rtl/scm_pkg.sv
package scm_pkg;

    typedef enum logic [1:0] {
        MODE_REAL     = 2'd0,
        MODE_BIT      = 2'd1,
        MODE_CPLX     = 2'd2,
        MODE_REAL_ALT = 2'd3
    } mode_e;

endpackage

// File: rtl/scm_code_reg.sv
module scm_code_reg #(
    parameter int TAPS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic            load_bit,
    output logic [TAPS-1:0] code_o
);

    typedef struct packed {
        logic [TAPS-1:0] code;
    } state_t;

    state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_en) begin
            nxt_d.code = {cur_q.code[TAPS-2:0], load_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign code_o = cur_q.code;

    // R5: weights change only through the serial load path
    a_r5_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(cur_q.code));

endmodule

// File: rtl/scm_delay_line.sv
module scm_delay_line #(
    parameter int TAPS     = 64,
    parameter int SAMPLE_W = 4,
    localparam int LINE_W  = TAPS * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [SAMPLE_W-1:0] din,
    output logic [LINE_W-1:0]   line_o,
    output logic [SAMPLE_W-1:0] tail_o
);

    typedef struct packed {
        logic [LINE_W-1:0] line;
    } state_t;

    state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (shift_en) begin
            nxt_d.line = {cur_q.line[LINE_W-SAMPLE_W-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign line_o = cur_q.line;
    assign tail_o = cur_q.line[LINE_W-1 -: SAMPLE_W];

    // R6: without an accepted sample the window must not move
    a_r6_line_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cur_q.line));

endmodule

// File: rtl/scm_tap_sum.sv
module scm_tap_sum
    import scm_pkg::*;
#(
    parameter int TAPS     = 64,
    parameter int SAMPLE_W = 4,
    parameter int SUM_W    = 11,
    localparam int HALF_W  = SAMPLE_W / 2,
    localparam int TERM_W  = SAMPLE_W + 1,
    localparam int LINE_W  = TAPS * SAMPLE_W
) (
    input  logic [LINE_W-1:0]       line,
    input  logic [TAPS-1:0]         code,
    input  mode_e                   mode,
    output logic signed [SUM_W-1:0] sum_i,
    output logic signed [SUM_W-1:0] sum_q
);

    logic [TAPS*TERM_W-1:0] terms_i;
    logic [TAPS*TERM_W-1:0] terms_q;

    for (genvar j = 0; j < TAPS; j++) begin : g_tap
        logic [SAMPLE_W-1:0]      smp;
        logic signed [TERM_W-1:0] raw_i;
        logic signed [TERM_W-1:0] raw_q;

        assign smp = line[j*SAMPLE_W +: SAMPLE_W];

        always_comb begin
            unique case (mode)
                MODE_BIT: begin
                    raw_i = smp[0] ? -TERM_W'(1) : TERM_W'(1);
                    raw_q = '0;
                end
                MODE_CPLX: begin
                    raw_i = TERM_W'($signed(smp[SAMPLE_W-1 -: HALF_W]));
                    raw_q = TERM_W'($signed(smp[HALF_W-1:0]));
                end
                default: begin
                    raw_i = TERM_W'($signed(smp));
                    raw_q = '0;
                end
            endcase
        end

        // bipolar weight: code bit 1 flips the sign, no multiplier
        assign terms_i[j*TERM_W +: TERM_W] = code[j] ? -raw_i : raw_i;
        assign terms_q[j*TERM_W +: TERM_W] = code[j] ? -raw_q : raw_q;
    end

    always_comb begin
        sum_i = '0;
        sum_q = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_i = sum_i + SUM_W'($signed(terms_i[k*TERM_W +: TERM_W]));
            sum_q = sum_q + SUM_W'($signed(terms_q[k*TERM_W +: TERM_W]));
        end
    end

endmodule

// File: rtl/spread_code_matcher.sv
module spread_code_matcher
    import scm_pkg::*;
#(
    parameter int TAPS     = 64,
    parameter int SAMPLE_W = 4,
    localparam int SUM_W   = $clog2(TAPS * (2 ** (SAMPLE_W - 1)) + 1) + 1,
    localparam int THR_W   = 2 * SUM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode,
    input  logic                    load_en,
    input  logic                    load_bit,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    input  logic [THR_W-1:0]        threshold,
    output logic                    out_valid,
    output logic signed [SUM_W-1:0] corr_i,
    output logic signed [SUM_W-1:0] corr_q,
    output logic                    peak,
    output logic [SAMPLE_W-1:0]     casc_sample
);

    localparam int LINE_W = TAPS * SAMPLE_W;

    typedef struct packed {
        logic                    vld1;
        logic                    out_valid;
        logic signed [SUM_W-1:0] corr_i;
        logic signed [SUM_W-1:0] corr_q;
        logic                    peak;
    } state_t;

    state_t cur_q, nxt_d;

    mode_e                   mode_sel;
    logic                    accept;
    logic [TAPS-1:0]         code;
    logic [LINE_W-1:0]       line;
    logic signed [SUM_W-1:0] sum_i;
    logic signed [SUM_W-1:0] sum_q;
    logic signed [THR_W-1:0] ext_i;
    logic signed [THR_W-1:0] ext_q;
    logic [THR_W-1:0]        metric;

    assign mode_sel = mode_e'(mode);
    assign accept   = in_valid & ~load_en;

    scm_code_reg #(.TAPS(TAPS)) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_bit (load_bit),
        .code_o   (code)
    );

    scm_delay_line #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_sample),
        .line_o   (line),
        .tail_o   (casc_sample)
    );

    scm_tap_sum #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_sum (
        .line  (line),
        .code  (code),
        .mode  (mode_sel),
        .sum_i (sum_i),
        .sum_q (sum_q)
    );

    assign ext_i = THR_W'(sum_i);
    assign ext_q = THR_W'(sum_q);

    // detection metric: power for complex, magnitude otherwise
    always_comb begin
        if (mode_sel == MODE_CPLX) begin
            metric = $unsigned(ext_i * ext_i) + $unsigned(ext_q * ext_q);
        end else if (sum_i[SUM_W-1]) begin
            metric = $unsigned(-ext_i);
        end else begin
            metric = $unsigned(ext_i);
        end
    end

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.vld1      = accept;
        nxt_d.out_valid = cur_q.vld1;
        nxt_d.peak      = 1'b0;
        if (cur_q.vld1) begin
            nxt_d.corr_i = sum_i;
            nxt_d.corr_q = sum_q;
            nxt_d.peak   = (metric >= threshold);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign out_valid = cur_q.out_valid;
    assign corr_i    = cur_q.corr_i;
    assign corr_q    = cur_q.corr_q;
    assign peak      = cur_q.peak;

    // R7: an accepted sample yields a result two edges on
    a_r7_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 out_valid);

    // R8: detection never fires without a fresh result
    a_r8_peak_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        peak |-> out_valid);

endmodule

// File: tb/spread_code_matcher_bench.sv
`timescale 1ns/1ps
module spread_code_matcher_bench;

    localparam int TAPS  = 64;
    localparam int SW    = 4;
    localparam int SUM_W = 11;
    localparam int THR_W = 22;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              mode = 2'd0;
    logic                    load_en = 1'b0;
    logic                    load_bit = 1'b0;
    logic                    in_valid = 1'b0;
    logic [SW-1:0]           in_sample = '0;
    logic [THR_W-1:0]        threshold = '0;
    logic                    out_valid;
    logic signed [SUM_W-1:0] corr_i;
    logic signed [SUM_W-1:0] corr_q;
    logic                    peak;
    logic [SW-1:0]           casc_sample;

    always #4 clk = ~clk;

    spread_code_matcher u_spread_code_matcher (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .load_en     (load_en),
        .load_bit    (load_bit),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .threshold   (threshold),
        .out_valid   (out_valid),
        .corr_i      (corr_i),
        .corr_q      (corr_q),
        .peak        (peak),
        .casc_sample (casc_sample)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    int              mline[$];
    logic [TAPS-1:0] mcode = '0;
    int              ref_code[TAPS];
    bit              pend = 1'b0;
    int              exp_i = 0, exp_q = 0;
    bit              exp_ov = 1'b0, exp_pk = 1'b0;
    bit              was_load = 1'b0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int dec_i(int s, int m);
        int h;
        if (m == 1) return (s & 1) ? -1 : 1;
        if (m == 2) begin
            h = (s >> 2) & 3;
            return (h >= 2) ? h - 4 : h;
        end
        return (s >= 8) ? s - 16 : s;
    endfunction

    function automatic int dec_q(int s, int m);
        int h;
        if (m != 2) return 0;
        h = s & 3;
        return (h >= 2) ? h - 4 : h;
    endfunction

    function automatic string corr_tag(int m);
        if (m == 1) return "R3";
        if (m == 2) return "R4";
        if (m == 3) return "R11";
        return "R2";
    endfunction

    task automatic step();
        int m, ei, eq, w, met;
        @(posedge clk);
        m = int'(mode);
        if (pend) begin
            ei = 0;
            eq = 0;
            for (int j = 0; j < TAPS; j++) begin
                w = mcode[j] ? -1 : 1;
                ei += w * dec_i(mline[j], m);
                eq += w * dec_q(mline[j], m);
            end
            exp_i  = ei;
            exp_q  = eq;
            exp_ov = 1'b1;
            met    = (m == 2) ? ei * ei + eq * eq : ((ei < 0) ? -ei : ei);
            exp_pk = (met >= int'(threshold));
        end else begin
            exp_ov = 1'b0;
            exp_pk = 1'b0;
        end
        was_load = load_en;
        pend = in_valid && !load_en;
        if (load_en) mcode = {mcode[TAPS-2:0], load_bit};
        if (in_valid && !load_en) begin
            mline.push_front(int'(in_sample));
            void'(mline.pop_back());
        end
        @(negedge clk);
        check(was_load ? "R6 out_valid" : "R7 out_valid", int'(out_valid), int'(exp_ov));
        check(exp_ov ? corr_tag(m) : "R10 hold i", int'(corr_i), exp_i);
        check(exp_ov ? corr_tag(m) : "R10 hold q", int'(corr_q), exp_q);
        check("R8 peak", int'(peak), int'(exp_pk));
        check(was_load ? "R6 casc" : "R9 casc", int'(casc_sample), mline[TAPS-1]);
    endtask

    task automatic random_run(int n, int pct);
        for (int k = 0; k < n; k++) begin
            in_valid  = (($urandom % 100) < pct);
            in_sample = SW'($urandom);
            step();
        end
        in_valid = 1'b0;
    endtask

    // R5, R6: serial load with stray sample strobes
    task automatic load_code();
        for (int j = 0; j < TAPS; j++) begin
            ref_code[j] = int'($urandom & 1);
            load_en   = 1'b1;
            load_bit  = ref_code[j][0];
            in_valid  = $urandom & 1;
            in_sample = SW'($urandom);
            step();
        end
        load_en  = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic send_code(int kind);
        for (int j = 0; j < TAPS; j++) begin
            in_valid = 1'b1;
            case (kind)
                1: in_sample = ref_code[j] ? 4'h1 : 4'h0;
                2: in_sample = ref_code[j] ? 4'h0 : 4'h1;
                3: in_sample = ref_code[j] ? 4'hF : 4'h5;
                default: in_sample = ref_code[j] ? 4'h9 : 4'h7;
            endcase
            step();
        end
        in_valid = 1'b0;
        step();
    endtask

    initial begin
        for (int j = 0; j < TAPS; j++) mline.push_back(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 peak", int'(peak), 0);
        check("R1 corr_i", int'(corr_i), 0);
        check("R1 corr_q", int'(corr_q), 0);
        check("R1 casc", int'(casc_sample), 0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", int'(out_valid), 0);

        load_code();
        mode = 2'd1;
        threshold = THR_W'(TAPS);
        random_run(40, 80);
        send_code(1);
        check("R5 matched one-bit sum", int'(corr_i), TAPS);
        check("R3 matched peak", int'(peak), 1);
        send_code(2);
        check("R3 inverted sum", int'(corr_i), -TAPS);
        check("R8 inverted peak", int'(peak), 1);
        random_run(60, 100);

        mode = 2'd0;
        threshold = THR_W'(200);
        random_run(300, 70);
        send_code(0);
        check("R2 matched real sum", int'(corr_i), 7 * TAPS);
        check("R2 matched corr_q", int'(corr_q), 0);

        load_code();
        mode = 2'd2;
        threshold = THR_W'(8000);
        random_run(300, 60);
        send_code(3);
        check("R4 matched i", int'(corr_i), TAPS);
        check("R4 matched q", int'(corr_q), TAPS);
        check("R8 complex peak", int'(peak), 1);
        threshold = THR_W'(20);
        random_run(200, 90);

        mode = 2'd3;
        threshold = THR_W'(60);
        random_run(200, 75);

        mode = 2'd0;
        threshold = '0;
        random_run(100, 50);
        load_code();
        threshold = THR_W'(120);
        random_run(200, 100);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule